// File: doc/BRIEF.md
# Masked CAM Packet Classifier

The block sorts packets into flows by comparing a 112-bit header key with a small table of stored filter entries. Each entry holds a value, a care-mask of the same width, a 16-bit flow identifier and a valid bit. A key bit is compared only where the entry's mask bit is 1; mask bits of 0 are "don't care". With masks, one entry can match an address prefix, any port, or the presence of chosen payload-list bits.

The key is built from the IPv4 source and destination addresses, the two transport ports, the protocol number and an 8-bit content vector. The content vector has one bit per payload list that an upstream scanner found in the packet. Software-side logic loads entries through a single write port. The datapath presents one key per cycle with a valid strobe. One cycle later the block returns a registered result: a valid flag, a hit flag and the flow ID of the matching entry with the lowest index. Entry 0 has the highest priority.

Top module: `cls_classifier`

## Requirements
- R1: After a synchronous active-low reset, `res_valid`, `res_hit` and `res_fid` are 0. Every table entry is invalid, so any key misses.
- R2: The key layout is as follows. Bits [111:80] are the source address, [79:48] the destination address, [47:32] the source port, [31:16] the destination port, [15:8] the protocol and [7:0] the content vector (bit n set means payload list n matched).
- R3: A valid entry matches a key when `(key & mask) == (value & mask)`. Key bits under a 0 mask bit have no effect on the outcome. An all-zero mask matches every key.
- R4: When several valid entries match, `res_fid` carries the flow ID of the matching entry with the lowest index.
- R5: When no valid entry matches, the result has `res_hit` = 0 and `res_fid` = 0.
- R6: An entry written with `wr_valid` = 0 never matches, whatever its value and mask are.
- R7: A key sampled with `key_valid` high at clock edge k gives `res_valid` = 1 after edge k. Keys on consecutive cycles each give their own result on consecutive cycles.
- R8: While `res_valid` is 0, `res_hit` and `res_fid` are 0.
- R9: A key presented in the same cycle as a table write is classified against the table contents from before that write. The written entry takes part from the next cycle on.
- R10: A content requirement is met by any packet that has at least the required list bits. For example, an entry with value 01 and mask 01 in the content field matches content 03 and does not match content 02.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write one table entry this cycle |
| wr_idx | input | IDX_W (3) | Index of the entry to write |
| wr_valid | input | 1 | Valid bit stored with the entry |
| wr_value | input | 112 | Value pattern of the entry |
| wr_mask | input | 112 | Care-mask of the entry (1 = compare) |
| wr_fid | input | 16 | Flow ID of the entry |
| key_valid | input | 1 | A key is presented this cycle |
| key | input | 112 | Header key, laid out as in R2 |
| res_valid | output | 1 | Result for the key of the previous cycle |
| res_hit | output | 1 | At least one valid entry matched |
| res_fid | output | 16 | Flow ID of the winning entry, 0 on a miss |

## Verification
A table write and a lookup can fall in the same cycle. The bench provokes this by writing a catch-all entry at index 0 while it presents a key that, before the write, matches only a lower-priority entry. In that cycle the result must still carry the old entry's flow ID. The same key presented in the next cycle must return the new entry's flow ID. A wrong write-before-read order shows up as the new ID arriving one cycle early.

// File: rtl/cls_pkg.sv
// Shared widths and types for the masked CAM classifier.
// Assumes a 112-bit key and 16-bit flow identifiers.
package cls_pkg;
    localparam int KEY_W = 112;
    localparam int FID_W = 16;

    typedef logic [KEY_W-1:0] key_t;
    typedef logic [FID_W-1:0] fid_t;
endpackage

// File: rtl/cls_entry_store.sv
// Entry table: value, care-mask, flow ID and valid bit per entry.
// One entry is written per cycle. A write becomes visible on the cycle
// after it is presented. Reset clears every entry.
module cls_entry_store
    import cls_pkg::*;
#(
    parameter int ENTRIES = 8,
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_valid,
    input  key_t             wr_value,
    input  key_t             wr_mask,
    input  fid_t             wr_fid,
    output key_t             value_q [ENTRIES],
    output key_t             mask_q  [ENTRIES],
    output fid_t             fid_q   [ENTRIES],
    output logic [ENTRIES-1:0] valid_q
);

    for (genvar i = 0; i < ENTRIES; i++) begin : g_entry
        // Hold one entry; load it when its index is written.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                value_q[i] <= '0;
                mask_q[i]  <= '0;
                fid_q[i]   <= '0;
                valid_q[i] <= 1'b0;
            end else if (wr_en && (wr_idx == IDX_W'(i))) begin
                value_q[i] <= wr_value;
                mask_q[i]  <= wr_mask;
                fid_q[i]   <= wr_fid;
                valid_q[i] <= wr_valid;
            end
        end
    end

    // R6: the stored valid bit follows what the write port asked for.
    a_r6_write_valid: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> valid_q[$past(wr_idx)] == $past(wr_valid));

endmodule

// File: rtl/cls_match_array.sv
// Ternary compare of one key against every stored entry at the same time.
// A hit needs a valid entry and equality on all bits whose mask bit is 1.
module cls_match_array
    import cls_pkg::*;
#(
    parameter int ENTRIES = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  key_t               key,
    input  key_t               value_q [ENTRIES],
    input  key_t               mask_q  [ENTRIES],
    input  logic [ENTRIES-1:0] valid_q,
    output logic [ENTRIES-1:0] hits
);

    for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
        // Compare only the cared-for bits of entry i.
        always_comb begin
            hits[i] = valid_q[i] && (((key ^ value_q[i]) & mask_q[i]) == '0);
        end

        // R6: an invalid entry never reports a hit.
        a_r6_invalid_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
            hits[i] |-> valid_q[i]);
    end

endmodule

// File: rtl/cls_prio_pick.sv
// Priority encoder: grants the lowest-indexed hit.
// Output is one-hot or zero. `any` reports that at least one entry hit.
module cls_prio_pick #(
    parameter int ENTRIES = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ENTRIES-1:0] hits,
    output logic [ENTRIES-1:0] grant,
    output logic               any
);

    // Scan upward and keep only the first hit.
    always_comb begin
        logic found;
        grant = '0;
        found = 1'b0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (hits[i] && !found) begin
                grant[i] = 1'b1;
                found    = 1'b1;
            end
        end
        any = found;
    end

    // R4: at most one winner, and it is one of the hits.
    a_r4_onehot_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
    a_r4_grant_is_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & ~hits) == '0);
    a_r4_hit_gets_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (hits != '0) |-> (grant != '0));

endmodule

// File: rtl/cls_classifier.sv
// Masked CAM packet classifier top.
// Takes one key per cycle and registers the result with one cycle of latency.
// Table writes take effect on the next cycle, so a lookup in the same cycle
// sees the old contents. The winning flow ID goes through a one-hot mux.
module cls_classifier
    import cls_pkg::*;
#(
    parameter int ENTRIES = 8,
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_valid,
    input  logic [KEY_W-1:0] wr_value,
    input  logic [KEY_W-1:0] wr_mask,
    input  logic [FID_W-1:0] wr_fid,
    input  logic             key_valid,
    input  logic [KEY_W-1:0] key,
    output logic             res_valid,
    output logic             res_hit,
    output logic [FID_W-1:0] res_fid
);

    key_t               value_q [ENTRIES];
    key_t               mask_q  [ENTRIES];
    fid_t               fid_q   [ENTRIES];
    logic [ENTRIES-1:0] valid_q;
    logic [ENTRIES-1:0] hits;
    logic [ENTRIES-1:0] grant;
    logic               any_hit;
    fid_t               sel_fid;

    cls_entry_store #(.ENTRIES(ENTRIES)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_valid (wr_valid),
        .wr_value (wr_value),
        .wr_mask  (wr_mask),
        .wr_fid   (wr_fid),
        .value_q  (value_q),
        .mask_q   (mask_q),
        .fid_q    (fid_q),
        .valid_q  (valid_q)
    );

    cls_match_array #(.ENTRIES(ENTRIES)) u_match (
        .clk     (clk),
        .rst_n   (rst_n),
        .key     (key),
        .value_q (value_q),
        .mask_q  (mask_q),
        .valid_q (valid_q),
        .hits    (hits)
    );

    cls_prio_pick #(.ENTRIES(ENTRIES)) u_pick (
        .clk   (clk),
        .rst_n (rst_n),
        .hits  (hits),
        .grant (grant),
        .any   (any_hit)
    );

    // One-hot AND-OR mux of the granted entry's flow ID.
    always_comb begin
        sel_fid = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            sel_fid = sel_fid | (fid_q[i] & {FID_W{grant[i]}});
        end
    end

    // Register the result. Hit and ID are cleared when no key came in.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_hit   <= 1'b0;
            res_fid   <= '0;
        end else begin
            res_valid <= key_valid;
            res_hit   <= key_valid && any_hit;
            res_fid   <= (key_valid && any_hit) ? sel_fid : '0;
        end
    end

    // R7: a result follows every accepted key one cycle later.
    a_r7_result_follows_key: assert property (@(posedge clk) disable iff (!rst_n)
        key_valid |=> res_valid);
    a_r7_no_spurious_result: assert property (@(posedge clk) disable iff (!rst_n)
        !key_valid |=> !res_valid);
    // R8: idle outputs stay at zero.
    a_r8_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> (!res_hit && res_fid == '0));
    // R5: a miss carries flow ID 0.
    a_r5_miss_zero_fid: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_hit) |-> res_fid == '0);

endmodule

// File: tb/tb_cls_classifier.sv
// Directed bench for the masked CAM classifier. Each scenario is one task
// that checks its own results.
module tb_cls_classifier;
    localparam int N   = 8;
    localparam int IW  = 3;
    localparam int KW  = 112;
    localparam int FW  = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [IW-1:0] wr_idx = '0;
    logic          wr_valid = 1'b0;
    logic [KW-1:0] wr_value = '0;
    logic [KW-1:0] wr_mask = '0;
    logic [FW-1:0] wr_fid = '0;
    logic          key_valid = 1'b0;
    logic [KW-1:0] key = '0;
    logic          res_valid;
    logic          res_hit;
    logic [FW-1:0] res_fid;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    cls_classifier #(.ENTRIES(N)) dut (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_valid(wr_valid),
        .wr_value(wr_value), .wr_mask(wr_mask), .wr_fid(wr_fid),
        .key_valid(key_valid), .key(key),
        .res_valid(res_valid), .res_hit(res_hit), .res_fid(res_fid)
    );

    // R2 layout: src, dst, sport, dport, proto, content.
    function automatic logic [KW-1:0] mk(input logic [31:0] s, input logic [31:0] d,
                                         input logic [15:0] sp, input logic [15:0] dp,
                                         input logic [7:0] pr, input logic [7:0] ct);
        return {s, d, sp, dp, pr, ct};
    endfunction

    localparam logic [KW-1:0] PKT  = {32'h80FC0505, 32'h8D8E0202, 16'h1000, 16'h0050, 8'h06, 8'h03};
    localparam logic [KW-1:0] FVAL = {32'h80FC0000, 32'h8D8E0000, 16'h0000, 16'h0050, 8'h06, 8'h01};
    localparam logic [KW-1:0] FMSK = {32'hFFFF0000, 32'hFFFF0000, 16'h0000, 16'hFFFF, 8'hFF, 8'h01};

    task automatic chk(input string req, input logic v, input logic h, input logic [FW-1:0] f,
                       input logic ev, input logic eh, input logic [FW-1:0] ef);
        n_tests++;
        if (v !== ev || h !== eh || f !== ef) begin
            n_fail++;
            $display("FAIL %s: got valid=%0b hit=%0b fid=%h, expected valid=%0b hit=%0b fid=%h",
                     req, v, h, f, ev, eh, ef);
        end
    endtask

    task automatic write_entry(input int idx, input logic vld, input logic [KW-1:0] val,
                               input logic [KW-1:0] msk, input logic [FW-1:0] fid);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = IW'(idx); wr_valid = vld;
        wr_value = val; wr_mask = msk; wr_fid = fid;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Present one key, sample just after the capturing edge, then idle.
    task automatic lookup(input logic [KW-1:0] k, input string req,
                          input logic eh, input logic [FW-1:0] ef);
        @(negedge clk);
        key_valid = 1'b1; key = k;
        @(posedge clk); #1;
        chk(req, res_valid, res_hit, res_fid, 1'b1, eh, ef);
        @(negedge clk);
        key_valid = 1'b0;
    endtask

    task automatic t_reset();
        @(posedge clk); #1;
        chk("R1 reset outputs", res_valid, res_hit, res_fid, 1'b0, 1'b0, '0);
        lookup(PKT, "R1 empty table misses", 1'b0, '0);
        lookup('0, "R1 zero key misses", 1'b0, '0);
    endtask

    task automatic t_example();
        write_entry(2, 1'b1, FVAL, FMSK, 16'h0BAD);
        lookup(PKT, "R2 R3 example match", 1'b1, 16'h0BAD);
        lookup(mk(32'h80FC1234, 32'h8D8EFFFF, 16'h9999, 16'h0050, 8'h06, 8'h01),
               "R3 dont-care bits ignored", 1'b1, 16'h0BAD);
        lookup(mk(32'h80FD0505, 32'h8D8E0202, 16'h1000, 16'h0050, 8'h06, 8'h03),
               "R3 cared bit differs", 1'b0, '0);
        lookup(mk(32'h80FC0505, 32'h8D8E0202, 16'h1000, 16'h0050, 8'h06, 8'h02),
               "R10 missing list bit", 1'b0, '0);
        lookup(mk(32'h80FC0505, 32'h8D8E0202, 16'h1000, 16'h0050, 8'h06, 8'h01),
               "R10 exact list bit", 1'b1, 16'h0BAD);
    endtask

    task automatic t_priority();
        write_entry(1, 1'b1, FVAL, {32'hFFFF0000, 96'h0}, 16'h1111);
        write_entry(5, 1'b1, FVAL, FMSK, 16'h5555);
        lookup(PKT, "R4 lowest index wins", 1'b1, 16'h1111);
    endtask

    task automatic t_invalid();
        write_entry(1, 1'b0, FVAL, {32'hFFFF0000, 96'h0}, 16'h1111);
        lookup(PKT, "R6 invalid entry skipped", 1'b1, 16'h0BAD);
    endtask

    task automatic t_miss();
        lookup(mk(32'h0A000001, 32'h0A000002, 16'h0001, 16'h0002, 8'h11, 8'h00),
               "R5 miss gives zero", 1'b0, '0);
    endtask

    task automatic t_pipeline();
        logic [KW-1:0] ks [3];
        logic          eh [3];
        logic [FW-1:0] ef [3];
        ks[0] = PKT;  eh[0] = 1'b1; ef[0] = 16'h0BAD;
        ks[1] = '0;   eh[1] = 1'b0; ef[1] = '0;
        ks[2] = mk(32'h80FC0000, 32'h8D8E0000, 16'h0, 16'h0050, 8'h06, 8'hFF);
        eh[2] = 1'b1; ef[2] = 16'h0BAD;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            key_valid = 1'b1; key = ks[i];
            @(posedge clk); #1;
            chk("R7 back-to-back result", res_valid, res_hit, res_fid, 1'b1, eh[i], ef[i]);
        end
        @(negedge clk);
        key_valid = 1'b0; key = PKT;
        @(posedge clk); #1;
        chk("R8 idle after burst", res_valid, res_hit, res_fid, 1'b0, 1'b0, '0);
    endtask

    task automatic t_same_cycle();
        @(negedge clk);
        wr_en = 1'b1; wr_idx = '0; wr_valid = 1'b1;
        wr_value = '0; wr_mask = '0; wr_fid = 16'h0F0F;
        key_valid = 1'b1; key = PKT;
        @(posedge clk); #1;
        chk("R9 lookup sees old table", res_valid, res_hit, res_fid, 1'b1, 1'b1, 16'h0BAD);
        @(negedge clk);
        wr_en = 1'b0;
        @(posedge clk); #1;
        chk("R9 write visible next cycle", res_valid, res_hit, res_fid, 1'b1, 1'b1, 16'h0F0F);
        @(negedge clk);
        key_valid = 1'b0;
        lookup(mk(32'h01020304, 32'h05060708, 16'h1, 16'h2, 8'h3, 8'h0),
               "R3 all-zero mask matches any", 1'b1, 16'h0F0F);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_example();
        t_priority();
        t_invalid();
        t_miss();
        t_pipeline();
        t_same_cycle();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_tests++;
                n_fail++;
                $display("FAIL watchdog: got timeout, expected completion");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule